// File: doc/BRIEF.md
# Serial Flash Hold-Condition Front End

This block sits at the pin side of a serial-flash-style SPI slave. It lets the bus master pause a transfer with an active-low pause pin (`hold_n_pin`) and later carry on from the same bit, without restarting the command. All four pins are brought into the system clock domain through two-flop synchronizers. A small state machine decides when a pause takes effect. Entry and exit are honoured only while the synchronized serial clock is low. A request made while the clock is high waits until the clock next falls.

The block gives the shift logic a qualified serial-clock edge strobe and a shift gate. It also gives the data-output driver its enable, and a status flag that shows whether a pause is active. It holds a bit position counter and the receive shift register, which are frozen during a pause. If chip select is released while paused, the block sends a one-cycle reset pulse to the command logic. It then refuses new traffic until the pause pin has gone high before chip select falls again. A busy indication from a write or erase timer passes through and is never affected by a pause.

Top module: `sf_hold_front`

## Requirements
- R1: After reset, `hold_active`, `dout_oe`, `shift_en`, `logic_rst`, `bit_pos` and `rx_word` are all 0.
- R2: With chip select high (`cs_n_pin`=1), driving `hold_n_pin` low never sets `hold_active`.
- R3: While selected, if `hold_n_pin` falls while `sck_pin` is low, `hold_active` is 1 within 4 system clock cycles.
- R4: While selected, if `hold_n_pin` falls while `sck_pin` is high, `hold_active` stays 0 until `sck_pin` goes low. It then becomes 1 within 4 cycles.
- R5: If `hold_n_pin` rises while `sck_pin` is low, `hold_active` clears within 4 cycles. If it rises while `sck_pin` is high, `hold_active` stays 1 until `sck_pin` goes low.
- R6: While `hold_active` is 1, `dout_oe` is 0, no `sclk_rise` or `sclk_fall` strobe occurs, and `sck_pin` and `din_pin` have no effect on `bit_pos` or `rx_word`.
- R7: A pause keeps `bit_pos` and `rx_word`. After the pause ends, the next rising serial clock edge continues from the stored bit position.
- R8: `busy_out` equals `busy_in` delayed by one system clock cycle, whether or not a pause is active.
- R9: Raising chip select during a pause produces exactly one `logic_rst` pulse of one cycle, clears `hold_active`, and clears `bit_pos` and `rx_word` to 0.
- R10: After R9, lowering chip select while `hold_n_pin` is still low gives no traffic: `shift_en` and `dout_oe` stay 0 and `bit_pos` stays 0. Traffic resumes only when `hold_n_pin` is high, chip select has been high with it, and chip select is then lowered.
- R11: While selected and not paused, `shift_en` and `dout_oe` are 1. Each rising `sck_pin` edge gives one `sclk_rise` strobe, increments `bit_pos` modulo the word width, and shifts `din_pin` into bit 0 of `rx_word`, with older bits moving toward the MSB. Deselecting clears `bit_pos` and `rx_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| hold_n_pin | input | 1 | Pause request pin, active low |
| din_pin | input | 1 | Serial data input pin |
| busy_in | input | 1 | Busy flag from the program/erase timer |
| sclk_rise | output | 1 | Qualified rising serial-clock strobe |
| sclk_fall | output | 1 | Qualified falling serial-clock strobe |
| shift_en | output | 1 | Gate for the shift and command logic |
| dout_oe | output | 1 | Output driver enable for serial data out |
| hold_active | output | 1 | A pause is in effect |
| logic_rst | output | 1 | One-cycle reset pulse for the command logic |
| bit_pos | output | BIT_W | Bit position within the current word |
| rx_word | output | WORD_W | Receive shift register contents |
| busy_out | output | 1 | Busy flag passed through, one cycle late |

## Verification
The hardest state to reach from the ports is the lockout after a chip-select release during a pause. The stimulus first pauses in the middle of a word. It then raises chip select while the pause pin stays low, and lowers chip select again before the pause pin is released. Only then can the bench show that serial clocks are ignored and that the pause pin must rise before a fresh select. Deferred entry and exit are reached by holding the serial clock high for several system cycles around each pause-pin edge. The bench checks the status flag before and after the clock falls.

// File: rtl/sfh_pkg.sv
package sfh_pkg;

  typedef enum logic [1:0] {
    ST_DESEL  = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PAUSED = 2'd2,
    ST_LOCKED = 2'd3
  } sfh_state_t;

  // Pause request may take effect: selected, pin low, serial clock low.
  function automatic logic pause_enter_ok(input logic cs_n, input logic hold_n,
                                          input logic sck);
    return !cs_n && !hold_n && !sck;
  endfunction

  // Pause release may take effect: pin high and serial clock low.
  function automatic logic pause_exit_ok(input logic hold_n, input logic sck);
    return hold_n && !sck;
  endfunction

  // Lockout ends only once both chip select and pause pin are high.
  function automatic logic lock_clear_ok(input logic cs_n, input logic hold_n);
    return cs_n && hold_n;
  endfunction

endpackage

// File: rtl/sfh_sync.sv
module sfh_sync #(
  parameter int W       = 4,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_in[b]};
    end
    assign d_out[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/sfh_fsm.sv
module sfh_fsm
  import sfh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output sfh_state_t state,
  output logic rst_pulse
);

  sfh_state_t nxt;
  logic       fire_rst;

  always_comb begin
    nxt      = state;
    fire_rst = 1'b0;
    unique case (state)
      ST_DESEL:  if (!cs_n_s) nxt = ST_ACTIVE;
      ST_ACTIVE: begin
        if (cs_n_s)                                  nxt = ST_DESEL;
        else if (pause_enter_ok(cs_n_s, hold_n_s, sck_s)) nxt = ST_PAUSED;
      end
      ST_PAUSED: begin
        if (cs_n_s) begin
          nxt      = ST_LOCKED;
          fire_rst = 1'b1;
        end else if (pause_exit_ok(hold_n_s, sck_s)) begin
          nxt = ST_ACTIVE;
        end
      end
      ST_LOCKED: if (lock_clear_ok(cs_n_s, hold_n_s)) nxt = ST_DESEL;
      default:   nxt = ST_DESEL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_DESEL;
      rst_pulse <= 1'b0;
    end else begin
      state     <= nxt;
      rst_pulse <= fire_rst;
    end
  end

endmodule

// File: rtl/sfh_shift.sv
module sfh_shift #(
  parameter int WORD_W = 8,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              din,
  output logic [BIT_W-1:0]  pos,
  output logic [WORD_W-1:0] word
);

  localparam logic [BIT_W-1:0] LAST = BIT_W'(WORD_W - 1);

  function automatic logic [BIT_W-1:0] next_pos(input logic [BIT_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      word <= '0;
    end else if (clear) begin
      pos  <= '0;
      word <= '0;
    end else if (step) begin
      pos  <= next_pos(pos);
      word <= {word[WORD_W-2:0], din};
    end
  end

endmodule

// File: rtl/sf_hold_front.sv
module sf_hold_front
  import sfh_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_pin,
  input  logic              sck_pin,
  input  logic              hold_n_pin,
  input  logic              din_pin,
  input  logic              busy_in,
  output logic              sclk_rise,
  output logic              sclk_fall,
  output logic              shift_en,
  output logic              dout_oe,
  output logic              hold_active,
  output logic              logic_rst,
  output logic [BIT_W-1:0]  bit_pos,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy_out
);

  // Synchronized pin bundle: {din, hold_n, sck, cs_n}
  localparam logic [3:0] PIN_IDLE = 4'b0101;

  logic [3:0] pins_s;
  logic       cs_n_s, sck_s, hold_n_s, din_s;
  logic       sck_d;
  sfh_state_t state;
  logic       in_lock;
  logic       clear_words;

  sfh_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({din_pin, hold_n_pin, sck_pin, cs_n_pin}),
    .d_out (pins_s)
  );

  assign cs_n_s   = pins_s[0];
  assign sck_s    = pins_s[1];
  assign hold_n_s = pins_s[2];
  assign din_s    = pins_s[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      busy_out <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      busy_out <= busy_in;
    end
  end

  sfh_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .sck_s     (sck_s),
    .hold_n_s  (hold_n_s),
    .state     (state),
    .rst_pulse (logic_rst)
  );

  assign shift_en    = (state == ST_ACTIVE);
  assign dout_oe     = shift_en;
  assign hold_active = (state == ST_PAUSED);
  assign in_lock     = (state == ST_LOCKED);
  assign sclk_rise   = shift_en && sck_s && !sck_d;
  assign sclk_fall   = shift_en && !sck_s && sck_d;
  assign clear_words = (state == ST_DESEL) || in_lock;

  sfh_shift #(.WORD_W(WORD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear_words),
    .step  (sclk_rise),
    .din   (din_s),
    .pos   (bit_pos),
    .word  (rx_word)
  );

endmodule

// File: rtl/sfh_checker.sv
module sfh_checker #(
  parameter int BIT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_s,
  input logic             sck_s,
  input logic             hold_n_s,
  input logic             hold_active,
  input logic             dout_oe,
  input logic             shift_en,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic             logic_rst,
  input logic             in_lock,
  input logic [BIT_W-1:0] bit_pos
);

  p_hold_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> !$past(cs_n_s));

  p_entry_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> !$past(sck_s) && !$past(hold_n_s));

  p_exit_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) && !logic_rst |-> !$past(sck_s) && $past(hold_n_s));

  p_oe_off_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !dout_oe && !sclk_rise && !sclk_fall);

  p_pos_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active && $past(hold_active) |-> $stable(bit_pos));

  p_rst_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst |=> !logic_rst);

  p_rst_from_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst |-> $past(hold_active) && in_lock);

  p_lock_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_lock |-> !shift_en && !dout_oe && !sclk_rise);

endmodule

bind sf_hold_front sfh_checker #(.BIT_W(BIT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n_s      (cs_n_s),
  .sck_s       (sck_s),
  .hold_n_s    (hold_n_s),
  .hold_active (hold_active),
  .dout_oe     (dout_oe),
  .shift_en    (shift_en),
  .sclk_rise   (sclk_rise),
  .sclk_fall   (sclk_fall),
  .logic_rst   (logic_rst),
  .in_lock     (in_lock),
  .bit_pos     (bit_pos)
);

// File: tb/sim_sf_hold_front.sv
module sim_sf_hold_front;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 8;
  localparam int BIT_W = $clog2(WORD_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n_pin = 1'b1, sck_pin = 1'b0, hold_n_pin = 1'b1, din_pin = 1'b0, busy_in = 1'b0;
  logic sclk_rise, sclk_fall, shift_en, dout_oe, hold_active, logic_rst, busy_out;
  logic [BIT_W-1:0]  bit_pos;
  logic [WORD_W-1:0] rx_word;

  int checks = 0;
  int errors = 0;
  int rise_cnt = 0;
  int rst_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sf_hold_front #(.WORD_W(WORD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
    .hold_n_pin(hold_n_pin), .din_pin(din_pin), .busy_in(busy_in),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .shift_en(shift_en),
    .dout_oe(dout_oe), .hold_active(hold_active), .logic_rst(logic_rst),
    .bit_pos(bit_pos), .rx_word(rx_word), .busy_out(busy_out)
  );

  always @(negedge clk) begin
    if (sclk_rise) rise_cnt++;
    if (logic_rst) rst_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sck_pulse();
    sck_pin = 1'b1; wait_cyc(4);
    sck_pin = 1'b0; wait_cyc(4);
  endtask

  task automatic send_bit(input logic b);
    din_pin = b; wait_cyc(4);
    sck_pulse();
  endtask

  task automatic t_reset();
    check("R1 hold_active", hold_active, 0);
    check("R1 dout_oe", dout_oe, 0);
    check("R1 shift_en", shift_en, 0);
    check("R1 logic_rst", logic_rst, 0);
    check("R1 bit_pos", bit_pos, 0);
    check("R1 rx_word", rx_word, 0);
  endtask

  task automatic t_normal();
    int r0;
    cs_n_pin = 1'b0; wait_cyc(4);
    check("R11 shift_en", shift_en, 1);
    check("R11 dout_oe", dout_oe, 1);
    r0 = rise_cnt;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    check("R11 rise strobes", rise_cnt - r0, 3);
    check("R11 bit_pos", bit_pos, 3);
    check("R11 rx_word", rx_word, 5);
    cs_n_pin = 1'b1; wait_cyc(4);
    check("R11 deselect clears pos", bit_pos, 0);
    check("R11 deselect clears word", rx_word, 0);
  endtask

  task automatic t_unselected();
    hold_n_pin = 1'b0; wait_cyc(6);
    check("R2 no hold when deselected", hold_active, 0);
    hold_n_pin = 1'b1; wait_cyc(4);
  endtask

  task automatic t_immediate();
    int r0;
    cs_n_pin = 1'b0; wait_cyc(4);
    send_bit(1'b1); send_bit(1'b1);
    hold_n_pin = 1'b0; wait_cyc(4);
    check("R3 hold entered", hold_active, 1);
    check("R6 oe off", dout_oe, 0);
    r0 = rise_cnt;
    din_pin = 1'b0;
    sck_pulse(); sck_pulse(); sck_pulse();
    check("R6 no strobes", rise_cnt - r0, 0);
    check("R7 pos kept", bit_pos, 2);
    check("R7 word kept", rx_word, 3);
    busy_in = 1'b1; wait_cyc(2);
    check("R8 busy during hold", busy_out, 1);
    busy_in = 1'b0; wait_cyc(2);
    check("R8 busy cleared", busy_out, 0);
    hold_n_pin = 1'b1; wait_cyc(4);
    check("R5 immediate exit", hold_active, 0);
    check("R5 oe back", dout_oe, 1);
    send_bit(1'b0);
    check("R7 resume pos", bit_pos, 3);
    check("R7 resume word", rx_word, 6);
    cs_n_pin = 1'b1; wait_cyc(4);
  endtask

  task automatic t_deferred();
    cs_n_pin = 1'b0; wait_cyc(4);
    din_pin = 1'b1; wait_cyc(2);
    sck_pin = 1'b1; wait_cyc(4);
    check("R11 pos after rise", bit_pos, 1);
    hold_n_pin = 1'b0; wait_cyc(6);
    check("R4 entry deferred", hold_active, 0);
    sck_pin = 1'b0; wait_cyc(4);
    check("R4 entry after clock low", hold_active, 1);
    sck_pin = 1'b1; wait_cyc(4);
    hold_n_pin = 1'b1; wait_cyc(6);
    check("R5 exit deferred", hold_active, 1);
    sck_pin = 1'b0; wait_cyc(4);
    check("R5 exit after clock low", hold_active, 0);
    check("R7 pos after deferred exit", bit_pos, 1);
    cs_n_pin = 1'b1; wait_cyc(4);
  endtask

  task automatic t_release();
    int r0;
    cs_n_pin = 1'b0; wait_cyc(4);
    send_bit(1'b1);
    hold_n_pin = 1'b0; wait_cyc(4);
    check("R9 paused before release", hold_active, 1);
    r0 = rst_cnt;
    cs_n_pin = 1'b1; wait_cyc(4);
    check("R9 one reset pulse", rst_cnt - r0, 1);
    check("R9 hold cleared", hold_active, 0);
    check("R9 pos cleared", bit_pos, 0);
    check("R9 word cleared", rx_word, 0);
    cs_n_pin = 1'b0; wait_cyc(4);
    check("R10 no shift while pin low", shift_en, 0);
    check("R10 no oe while pin low", dout_oe, 0);
    send_bit(1'b1);
    check("R10 clocks ignored", bit_pos, 0);
    hold_n_pin = 1'b1; wait_cyc(4);
    check("R10 still locked", shift_en, 0);
    cs_n_pin = 1'b1; wait_cyc(4);
    cs_n_pin = 1'b0; wait_cyc(4);
    check("R10 reselect resumes", shift_en, 1);
    cs_n_pin = 1'b1; wait_cyc(4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_normal();
    t_unselected();
    t_immediate();
    t_deferred();
    t_release();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule